// File: doc/BRIEF.md
# Multi-cycle processor control sequencer

This block is the control unit of a multi-cycle load/store processor. It steps the datapath through instruction fetch, decode with register read, then per-instruction execute, memory and write-back steps. Each step takes one clock. Every control output depends only on the current step, so the outputs form a Moore machine. Five instruction classes are handled: word load, word store, register-to-register ALU operations, branch-if-equal and jump.

Two further steps handle exceptions. One traps an opcode the unit does not recognise. The other traps an arithmetic overflow reported by the ALU during register-to-register execution. Both steps save the faulting address and a cause code, then load the program counter from the exception source. The datapath, ALU, function-field decoder and memories sit outside this block.

Reset is asynchronous and active low. It is asserted at once and released through a two-flop synchronizer. While reset is held, the sequencer sits in the fetch step.

Top module: `mcc_ctrl`

## Requirements
- R1: While reset is asserted, and for two clock edges after its release, the outputs are those of the fetch step. An assertion of rst_n mid-run returns the outputs to the fetch step without waiting for a clock edge.
- R2: Fetch step: pc_wr=1, mem_rd=1, ir_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_sel=00. The next step is always decode.
- R3: Decode step: alu_a_sel=0, alu_b_sel=11, alu_op=00. The next step depends on the opcode: 100011 (load) or 101011 (store) go to address compute, 000000 (register ALU) goes to execute, 000100 (branch-equal) goes to branch, and 000010 (jump) goes to jump.
- R4: Address-compute step: alu_a_sel=1, alu_b_sel=10, alu_op=00. Opcode 100011 continues to the load read step; any other opcode continues to the store step.
- R5: Load read step: mem_rd=1, addr_sel=1, then load write-back. Load write-back step: rf_wr=1, rd_sel=0, wb_sel=1, then fetch.
- R6: Store step: mem_wr=1, addr_sel=1, then fetch.
- R7: Execute step: alu_a_sel=1, alu_b_sel=00, alu_op=10. With alu_ovf low, the next step is register write-back: rf_wr=1, rd_sel=1, wb_sel=0, then fetch.
- R8: Branch step: alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_wr_cond=1, pc_sel=01, then fetch.
- R9: Jump step: pc_wr=1, pc_sel=10, then fetch.
- R10: Any opcode not listed in R3 leads from decode to the undefined-opcode trap step. That step drives cause_wr=1, epc_wr=1, pc_wr=1, pc_sel=11, alu_a_sel=0, alu_b_sel=01, alu_op=01 and cause_code=0, then goes to fetch.
- R11: alu_ovf high in the execute step leads to the overflow trap step instead of write-back, so no register is written. That step drives the same outputs as R10 except cause_code=1, then goes to fetch.
- R12: Every output not named for a step is 0 in that step. alu_ovf has no effect in any step other than execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed overflow flag |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when ALU result is zero |
| pc_sel | output | 2 | Program counter source select |
| addr_sel | output | 1 | Memory address select (0 = PC, 1 = ALU result register) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| rd_sel | output | 1 | Destination register field select |
| rf_wr | output | 1 | Register file write |
| wb_sel | output | 1 | Write-back data select (1 = memory data) |
| alu_a_sel | output | 1 | ALU operand A select |
| alu_b_sel | output | 2 | ALU operand B select |
| alu_op | output | 2 | ALU operation class |
| epc_wr | output | 1 | Exception address register write |
| cause_wr | output | 1 | Cause register write |
| cause_code | output | 1 | Cause value (0 = undefined opcode, 1 = overflow) |

## Verification
Overflow detection and register write-back compete for the same moment: the cycle after execute. The bench sweeps all 64 opcodes twice, once with alu_ovf held low and once with it held high for the whole instruction. The high pass therefore raises the flag during execute and also during every other step. For register ALU opcodes the bench expects the overflow trap outputs (rf_wr=0, cause_code=1) in the cycle after execute. For all other opcodes it expects the same step sequence as the low pass, which shows the flag is ignored outside execute.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W = 6;
  localparam int ST_W  = 4;

  localparam logic [OPC_W-1:0] OPC_ALU   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'b000010;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_LD_RD   = 4'd3,
    ST_LD_WB   = 4'd4,
    ST_ST_WR   = 4'd5,
    ST_EXEC    = 4'd6,
    ST_ALU_WB  = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9,
    ST_TRAP_OP = 4'd10,
    ST_TRAP_OV = 4'd11
  } st_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_sel;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       rd_sel;
    logic       rf_wr;
    logic       wb_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       epc_wr;
    logic       cause_wr;
    logic       cause_code;
  } ctrl_t;
endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  st_e              state_q,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output st_e              state_d
);
  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_LOAD, OPC_STORE: state_d = ST_ADDR;
          OPC_ALU:             state_d = ST_EXEC;
          OPC_BEQ:             state_d = ST_BRANCH;
          OPC_JMP:             state_d = ST_JUMP;
          default:             state_d = ST_TRAP_OP;
        endcase
      end
      ST_ADDR:   state_d = (opcode == OPC_LOAD) ? ST_LD_RD : ST_ST_WR;
      ST_LD_RD:  state_d = ST_LD_WB;
      ST_EXEC:   state_d = alu_ovf ? ST_TRAP_OV : ST_ALU_WB;
      default:   state_d = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  st_e   state_q,
  output ctrl_t ctrl
);
  always_comb begin
    ctrl = '0;
    case (state_q)
      ST_FETCH: begin
        ctrl.pc_wr     = 1'b1;
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_wr     = 1'b1;
        ctrl.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctrl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = 2'b10;
      end
      ST_LD_RD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LD_WB: begin
        ctrl.rf_wr  = 1'b1;
        ctrl.wb_sel = 1'b1;
      end
      ST_ST_WR: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_op    = 2'b10;
      end
      ST_ALU_WB: begin
        ctrl.rf_wr  = 1'b1;
        ctrl.rd_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_op     = 2'b01;
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_sel     = 2'b01;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_sel = 2'b10;
      end
      ST_TRAP_OP, ST_TRAP_OV: begin
        ctrl.cause_wr   = 1'b1;
        ctrl.epc_wr     = 1'b1;
        ctrl.pc_wr      = 1'b1;
        ctrl.pc_sel     = 2'b11;
        ctrl.alu_b_sel  = 2'b01;
        ctrl.alu_op     = 2'b01;
        ctrl.cause_code = (state_q == ST_TRAP_OV);
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic [1:0]       pc_sel,
  output logic             addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             rd_sel,
  output logic             rf_wr,
  output logic             wb_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             epc_wr,
  output logic             cause_wr,
  output logic             cause_code
);
  localparam int RST_STAGES = 2;

  logic  rst_sync_n;
  st_e   state_q;
  st_e   state_d;
  ctrl_t ctrl;

  mcc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcc_next_state u_ns (
    .state_q (state_q),
    .opcode  (opcode),
    .alu_ovf (alu_ovf),
    .state_d (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_FETCH;
    else             state_q <= state_d;
  end

  mcc_out_decode u_dec (
    .state_q (state_q),
    .ctrl    (ctrl)
  );

  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign pc_sel     = ctrl.pc_sel;
  assign addr_sel   = ctrl.addr_sel;
  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign ir_wr      = ctrl.ir_wr;
  assign rd_sel     = ctrl.rd_sel;
  assign rf_wr      = ctrl.rf_wr;
  assign wb_sel     = ctrl.wb_sel;
  assign alu_a_sel  = ctrl.alu_a_sel;
  assign alu_b_sel  = ctrl.alu_b_sel;
  assign alu_op     = ctrl.alu_op;
  assign epc_wr     = ctrl.epc_wr;
  assign cause_wr   = ctrl.cause_wr;
  assign cause_code = ctrl.cause_code;

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  assert_load_path_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ADDR && opcode == OPC_LOAD) |=> (state_q == ST_LD_RD));

  assert_store_excl_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr |-> (!mem_rd && !rf_wr && !ir_wr));

  assert_undef_trap_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DECODE && opcode != OPC_ALU && opcode != OPC_LOAD &&
     opcode != OPC_STORE && opcode != OPC_BEQ && opcode != OPC_JMP)
    |=> (cause_wr && !cause_code));

  assert_ovf_trap_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_EXEC && alu_ovf) |=> (cause_wr && cause_code && !rf_wr));

  assert_no_trap_outside_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_DECODE && state_q != ST_EXEC) |=> !cause_wr);
endmodule

// File: tb/sim_mcc_ctrl.sv
`timescale 1ns/1ps
module sim_mcc_ctrl;
  localparam time CLK_P = 5ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic       alu_ovf = 1'b0;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
  logic       rd_sel, rf_wr, wb_sel, alu_a_sel, epc_wr, cause_wr, cause_code;
  logic [1:0] pc_sel, alu_b_sel, alu_op;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  mcc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_ovf(alu_ovf),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_sel(pc_sel),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .rd_sel(rd_sel), .rf_wr(rf_wr), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .epc_wr(epc_wr),
    .cause_wr(cause_wr), .cause_code(cause_code)
  );

  wire [18:0] obs = {pc_wr, pc_wr_cond, pc_sel, addr_sel, mem_rd, mem_wr, ir_wr,
                     rd_sel, rf_wr, wb_sel, alu_a_sel, alu_b_sel, alu_op,
                     epc_wr, cause_wr, cause_code};

  // Expected outputs per step, taken from R2..R12 (unnamed outputs are 0).
  function automatic logic [18:0] exp_out(input int s);
    logic pw, pwc, ad, mr, mw, iw, rd, rw, wb, a, ew, cw, cc;
    logic [1:0] ps, b, op;
    {pw, pwc, ad, mr, mw, iw, rd, rw, wb, a, ew, cw, cc} = '0;
    ps = 2'b00; b = 2'b00; op = 2'b00;
    case (s)
      0:  begin pw = 1; mr = 1; iw = 1; b = 2'b01; end
      1:  b = 2'b11;
      2:  begin a = 1; b = 2'b10; end
      3:  begin mr = 1; ad = 1; end
      4:  begin rw = 1; wb = 1; end
      5:  begin mw = 1; ad = 1; end
      6:  begin a = 1; op = 2'b10; end
      7:  begin rw = 1; rd = 1; end
      8:  begin a = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      9:  begin pw = 1; ps = 2'b10; end
      10, 11: begin cw = 1; ew = 1; pw = 1; ps = 2'b11; b = 2'b01; op = 2'b01;
                    cc = (s == 11); end
      default: ;
    endcase
    return {pw, pwc, ps, ad, mr, mw, iw, rd, rw, wb, a, b, op, ew, cw, cc};
  endfunction

  function automatic int exp_next(input int s, input logic [5:0] opc, input logic ovf);
    case (s)
      0: return 1;
      1: case (opc)
           6'b100011, 6'b101011: return 2;
           6'b000000: return 6;
           6'b000100: return 8;
           6'b000010: return 9;
           default:   return 10;
         endcase
      2: return (opc == 6'b100011) ? 3 : 5;
      3: return 4;
      6: return ovf ? 11 : 7;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3, 4: return "R5"; 5: return "R6"; 6, 7: return "R7";
      8: return "R8"; 9: return "R9"; 10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [18:0] exp);
    vectors++;
    if (obs !== exp) begin
      miscompares++;
      $display("FAIL %s: outputs %b expected %b (opcode %b ovf %b)", req, obs, exp, opcode, alu_ovf);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset holds fetch outputs, including two edges after release
    repeat (3) @(negedge clk);
    check("R1", exp_out(0));
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", exp_out(0));
    @(posedge clk); @(negedge clk);
    check("R1", exp_out(0));

    // Sweep every opcode with overflow low, then held high (R12: ignored outside execute)
    for (int pass = 0; pass < 2; pass++) begin
      for (int opc = 0; opc < 64; opc++) begin
        int s = 0;
        opcode  = opc[5:0];
        alu_ovf = pass[0];
        do begin
          check(req_of(s), exp_out(s));
          if (s != 0) check("R12", exp_out(s));
          s = exp_next(s, opcode, alu_ovf);
          @(posedge clk); @(negedge clk);
        end while (s != 0);
        check("R2", exp_out(0));
      end
    end

    // R1: asynchronous reset in the middle of an ALU instruction
    opcode = 6'b000000; alu_ovf = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R7", exp_out(6));
    rst_n = 1'b0;
    #1;
    check("R1", exp_out(0));
    @(posedge clk); @(negedge clk);
    check("R1", exp_out(0));
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1", exp_out(0));
    @(posedge clk); @(negedge clk);
    check("R3", exp_out(1));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule